// File: doc/BRIEF.md
# Live Phase-Stepping Clock Divider Bank

This block drives a bank of divided clock outputs from one fast reference clock. Each channel has its own integer divider. Every channel can also be moved later in phase by whole reference cycles while its output keeps toggling. Software arms a channel by clearing its delay power-down bit and setting its dynamic-delay enable. It selects the step-count write as the trigger source, and then writes a step count. Each armed channel then replaces that many normal divide periods with stretched periods. Each stretched period is set by a programmed high count and low count.

A stretched period lasts high + low reference cycles instead of the divide value. Each step therefore delays the channel by high + low − divide cycles against channels that did not take part. Delays add up across writes. A stretched period always starts on a normal period boundary, which is a rising edge, so the output never shows a runt pulse. A busy flag covers a stepping burst, and step writes that arrive during the burst are dropped.

Top module: `ddly_clk_div`

## Requirements
- R1: While reset is asserted, all outputs and `busy_o` are 0. After release, every channel starts with a rising edge on the same reference cycle, so all channels are phase aligned.
- R2: In normal operation a channel repeats a period of D reference cycles, where D is its divide value (values below 2 count as 2). The output is high for the first floor(D/2) cycles of each period.
- R3: Register map on the write port. Address 0 bits [1:0] hold the trigger select. Address 1 bits [STEP_W-1:0] hold the step count. For channel c, address 2+2c holds the divide value in [7:0], the high count in [15:8] and the low count in [23:16]. Address 3+2c holds power-down in bit 0, dynamic enable in bit 1 and sync-disable in bit 2. After reset the divide is 8, high is 4, low is 5, power-down is 1, and the other bits are 0.
- R4: A step write of N ≥ 1, accepted while the trigger select is 3, makes each taking-part channel run N adjustment periods. Each adjustment period is high for the high count and then low for the low count. The result is a delay of N·(high+low−D) cycles relative to channels that do not take part.
- R5: Delays from successive accepted step writes add up.
- R6: A channel takes part only when power-down is 0, dynamic enable is 1 and sync-disable is 0 at the time of the trigger. Any other channel keeps its phase.
- R7: A step write while the trigger select is not 3 has no effect on any output, and `busy_o` stays low.
- R8: A step write of 0 adds no delay and leaves `busy_o` low.
- R9: `busy_o` rises in the cycle after an accepted step write. It stays high until the last adjustment period of the burst has started. Step writes made while `busy_o` is high are ignored.
- R10: An adjustment period begins only at the boundary of a normal period, so its high phase lasts exactly the high count.
- R11: An adjustment period is legal only if the high and low counts are each at least 1 and high + low ≥ D. An illegal setting is replaced by a normal period, so it adds zero delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| div_clk_o | output | NUM_CH | Divided clock outputs, one bit per channel |
| busy_o | output | 1 | A step burst is in progress |

## Verification
A wrong period counter or wrong adjustment-length selection shows up as a wrong phase offset between a taking-part channel and a reference channel. That offset is visible at the first rising edge after the burst ends, within two periods. A wrong pending-step count either keeps `busy_o` high for extra adjustment periods or leaves the offset short by whole step sizes. Gating faults in the trigger, the participation bits or the zero-count case show up as a nonzero offset change, or as `busy_o` pulsing, in the cycle right after the write.

// File: rtl/ddly_pkg.sv
package ddly_pkg;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 3 * CNT_W;
  localparam int DEF_DIV = 8;
  localparam int DEF_HI  = 4;
  localparam int DEF_LO  = 5;

  localparam logic [ADDR_W-1:0] ADDR_TRIG    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STEP    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CH_BASE = ADDR_W'(2);
  localparam logic [1:0]        TRIG_ON_STEP = 2'd3;

  typedef struct packed {
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] div;
  } ch_tim_t;

  typedef struct packed {
    logic sync_dis;
    logic dyn_en;
    logic pd;
  } ch_ctl_t;
endpackage

// File: rtl/ddly_cfg_regs.sv
module ddly_cfg_regs
  import ddly_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [1:0]        trig_sel_o,
  output ch_tim_t           tim_o [NUM_CH],
  output ch_ctl_t           ctl_o [NUM_CH]
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_sel_o <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_TRIG) trig_sel_o <= wr_data_i[1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] TIM_ADDR = ADDR_W'(int'(ADDR_CH_BASE) + 2 * c);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(int'(ADDR_CH_BASE) + 2 * c + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tim_o[c] <= '{lo: CNT_W'(DEF_LO), hi: CNT_W'(DEF_HI), div: CNT_W'(DEF_DIV)};
        ctl_o[c] <= '{sync_dis: 1'b0, dyn_en: 1'b0, pd: 1'b1};
      end else if (wr_en_i) begin
        if (wr_addr_i == TIM_ADDR) tim_o[c] <= ch_tim_t'(wr_data_i);
        if (wr_addr_i == CTL_ADDR) ctl_o[c] <= ch_ctl_t'(wr_data_i[2:0]);
      end
    end
  end

endmodule

// File: rtl/ddly_step_ctrl.sv
module ddly_step_ctrl
  import ddly_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [STEP_W-1:0] step_data_i,
  input  logic [1:0]        trig_sel_i,
  input  logic [NUM_CH-1:0] ch_busy_i,
  output logic              start_o,
  output logic [STEP_W-1:0] steps_o,
  output logic              busy_o
);

  logic accept;

  // start_o covers the cycle before channels load their pending count
  assign busy_o = start_o | (|ch_busy_i);
  assign accept = wr_en_i && (wr_addr_i == ADDR_STEP) && (trig_sel_i == TRIG_ON_STEP)
                  && (step_data_i != '0) && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      steps_o <= '0;
    end else begin
      start_o <= accept;
      if (accept) steps_o <= step_data_i;
    end
  end

endmodule

// File: rtl/ddly_ch_div.sv
module ddly_ch_div
  import ddly_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_tim_t           tim_i,
  input  ch_ctl_t           ctl_i,
  input  logic              start_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic              clk_o,
  output logic              busy_o
);

  localparam int LW = CNT_W + 1;

  logic [LW-1:0]     div_eff, adj_len, hi_ext;
  logic [LW-1:0]     cnt_q, cnt_d, len_q, len_d, hi_q, hi_d;
  logic [STEP_W-1:0] pend_q, pend_d;
  logic              out_d, adj_ok, joined, wrap;

  assign div_eff = (tim_i.div < CNT_W'(2)) ? LW'(2) : {1'b0, tim_i.div};
  assign hi_ext  = {1'b0, tim_i.hi};
  assign adj_len = hi_ext + {1'b0, tim_i.lo};
  assign adj_ok  = (tim_i.hi != '0) && (tim_i.lo != '0) && (adj_len >= div_eff);
  assign joined  = !ctl_i.pd && ctl_i.dyn_en && !ctl_i.sync_dis;
  assign wrap    = (cnt_q == len_q - LW'(1));

  always_comb begin
    cnt_d  = cnt_q + LW'(1);
    len_d  = len_q;
    hi_d   = hi_q;
    pend_d = pend_q;
    if (wrap) begin
      // period boundary: pick the length of the next period
      cnt_d = '0;
      len_d = div_eff;
      hi_d  = div_eff >> 1;
      if (pend_q != '0) begin
        pend_d = pend_q - STEP_W'(1);
        if (adj_ok) begin
          len_d = adj_len;
          hi_d  = hi_ext;
        end
      end
    end
    if (start_i && joined && pend_q == '0) pend_d = steps_i;
    out_d = (cnt_d < hi_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LW'(DEF_DIV - 1);
      len_q  <= LW'(DEF_DIV);
      hi_q   <= LW'(DEF_DIV / 2);
      pend_q <= '0;
      clk_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      hi_q   <= hi_d;
      pend_q <= pend_d;
      clk_o  <= out_d;
    end
  end

  assign busy_o = (pend_q != '0);

endmodule

// File: rtl/ddly_clk_div.sv
module ddly_clk_div
  import ddly_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] div_clk_o,
  output logic              busy_o
);

  logic [1:0]        trig_sel;
  ch_tim_t           tim [NUM_CH];
  ch_ctl_t           ctl [NUM_CH];
  logic [NUM_CH-1:0] ch_busy;
  logic              start;
  logic [STEP_W-1:0] steps;

  ddly_cfg_regs #(.NUM_CH(NUM_CH)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .trig_sel_o(trig_sel),
    .tim_o     (tim),
    .ctl_o     (ctl)
  );

  ddly_step_ctrl #(.NUM_CH(NUM_CH), .STEP_W(STEP_W)) i_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .step_data_i(wr_data_i[STEP_W-1:0]),
    .trig_sel_i (trig_sel),
    .ch_busy_i  (ch_busy),
    .start_o    (start),
    .steps_o    (steps),
    .busy_o     (busy_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ddly_ch_div #(.STEP_W(STEP_W)) i_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tim_i  (tim[c]),
      .ctl_i  (ctl[c]),
      .start_i(start),
      .steps_i(steps),
      .clk_o  (div_clk_o[c]),
      .busy_o (ch_busy[c])
    );
  end

endmodule

// File: rtl/ddly_clk_div_chk.sv
module ddly_clk_div_chk
  import ddly_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [STEP_W-1:0] step_data_i,
  input logic [1:0]        trig_sel_i,
  input logic              busy_i
);

  logic step_wr, step_nz, trig_on;
  assign step_wr = wr_en_i && (wr_addr_i == ADDR_STEP);
  assign step_nz = (step_data_i != '0);
  assign trig_on = (trig_sel_i == TRIG_ON_STEP);

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_wr && trig_on && step_nz && !busy_i |=> busy_i); // R9

  AST_BUSY_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(step_wr && trig_on && step_nz)); // R9

  AST_ZERO_STEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_wr && !step_nz && !busy_i |=> !busy_i); // R8

  AST_TRIG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_wr && !trig_on && !busy_i |=> !busy_i); // R7

endmodule

bind ddly_clk_div ddly_clk_div_chk #(.STEP_W(STEP_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .step_data_i(wr_data_i[STEP_W-1:0]),
  .trig_sel_i (trig_sel),
  .busy_i     (busy_o)
);

// File: tb/test_ddly_clk_div.sv
module test_ddly_clk_div;
  import ddly_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 2;
  localparam int STEP_W = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NUM_CH-1:0] div_clk;
  logic              busy;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddly_clk_div #(.NUM_CH(NUM_CH), .STEP_W(STEP_W)) i_ddly_clk_div (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .div_clk_o(div_clk),
    .busy_o   (busy)
  );

  typedef struct packed {
    logic [3:0] steps;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [3:0] exp_off;
    logic [3:0] req;
  } vec_t;

  // channel 1 timing + step count; expected offset of ch1 after ch0 (mod 8)
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1, 8'd4, 8'd5, 4'd1, 4'd4},  // R4 one step of +1
    '{4'd2, 8'd4, 8'd5, 4'd3, 4'd5},  // R5 two more accumulate
    '{4'd0, 8'd4, 8'd5, 4'd3, 4'd8},  // R8 zero steps
    '{4'd1, 8'd4, 8'd6, 4'd5, 4'd4},  // R4 step of +2
    '{4'd1, 8'd3, 8'd3, 4'd5, 4'd11}, // R11 sum below divide
    '{4'd1, 8'd0, 8'd9, 4'd5, 4'd11}, // R11 zero high count
    '{4'd2, 8'd4, 8'd4, 4'd5, 4'd11}  // R11 zero-delay legal setting
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic settle();
    int g = 0;
    repeat (2) @(negedge clk);
    while (busy && g < 500) begin
      @(negedge clk);
      g++;
    end
    repeat (30) @(negedge clk);
  endtask

  // cycles from a ch0 rising edge to the next ch1 rising edge
  task automatic meas_off(output int off);
    logic a0, a1, b0, b1;
    int g = 0;
    off = -1;
    @(negedge clk);
    a0 = div_clk[0]; a1 = div_clk[1];
    forever begin
      @(negedge clk);
      b0 = div_clk[0]; b1 = div_clk[1];
      g++;
      if ((b0 && !a0) || g > 100) break;
      a0 = b0; a1 = b1;
    end
    if (b1 && !a1) begin
      off = 0;
      return;
    end
    for (int k = 1; k < 100; k++) begin
      a1 = b1;
      @(negedge clk);
      b1 = div_clk[1];
      if (b1 && !a1) begin
        off = k;
        return;
      end
    end
  endtask

  task automatic meas_ch0(output int hi, output int per);
    logic p;
    int g = 0;
    hi = 0; per = 0;
    @(negedge clk);
    p = div_clk[0];
    forever begin
      @(negedge clk);
      g++;
      if ((div_clk[0] && !p) || g > 100) break;
      p = div_clk[0];
    end
    hi = 1; per = 1; p = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (div_clk[0] && !p) break;
      if (div_clk[0]) hi++;
      per++;
      p = div_clk[0];
    end
  endtask

  task automatic max_high_ch1(input int ncyc, output int mx);
    int run = 0;
    mx = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (div_clk[1]) run++;
      else run = 0;
      if (run > mx) mx = run;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int off, hi, per, mx, exp_off;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", int'(div_clk), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_ni = 1'b1;
    meas_ch0(hi, per);
    chk("R2 default high", hi, 4);
    chk("R2 default period", per, 8);
    meas_off(off);
    chk("R1 aligned after reset", off, 0);

    // R3 arm channel 1, trigger on step write; ch0 stays powered down
    wr(0, DATA_W'(3));
    wr(5, DATA_W'(3'b010));
    meas_off(off);
    chk("R3 arming alone adds no delay", off, 0);

    for (int i = 0; i < NVEC; i++) begin
      wr(4, {VECS[i].lo, VECS[i].hi, 8'd8});
      wr(1, DATA_W'(VECS[i].steps));
      if (VECS[i].steps == 0) chk("R8 busy after zero write", int'(busy), 0);
      settle();
      meas_off(off);
      chk($sformatf("R%0d vector %0d offset", VECS[i].req, i), off, int'(VECS[i].exp_off));
    end
    exp_off = 5;

    // R7 trigger not selected
    wr(4, {8'd5, 8'd4, 8'd8});
    wr(0, DATA_W'(1));
    wr(1, DATA_W'(2));
    chk("R7 busy stays low", int'(busy), 0);
    settle();
    meas_off(off);
    chk("R7 offset unchanged", off, exp_off);
    wr(0, DATA_W'(3));

    // R6 participation gating: sync-disabled, powered down, dynamic off
    wr(5, DATA_W'(3'b110));
    wr(1, DATA_W'(1));
    settle();
    meas_off(off);
    chk("R6 sync disabled", off, exp_off);
    wr(5, DATA_W'(3'b011));
    wr(1, DATA_W'(1));
    settle();
    meas_off(off);
    chk("R6 powered down", off, exp_off);
    wr(5, DATA_W'(3'b000));
    wr(1, DATA_W'(1));
    settle();
    meas_off(off);
    chk("R6 dynamic disabled", off, exp_off);
    wr(5, DATA_W'(3'b010));

    // R9 busy window, write during busy dropped
    wr(1, DATA_W'(3));
    chk("R9 busy after accept", int'(busy), 1);
    wr(1, DATA_W'(2));
    chk("R9 busy during burst", int'(busy), 1);
    settle();
    chk("R9 busy cleared", int'(busy), 0);
    meas_off(off);
    exp_off = (exp_off + 3) % 8;
    chk("R9 second write ignored", off, exp_off);

    // R10 stretched high phase equals high count
    wr(4, {8'd3, 8'd6, 8'd8});
    wr(1, DATA_W'(1));
    max_high_ch1(40, mx);
    chk("R10 adjustment high width", mx, 6);
    settle();
    meas_off(off);
    exp_off = (exp_off + 1) % 8;
    chk("R10 offset after stretched step", off, exp_off);

    // R2 R3 new divide on channel 0
    wr(2, {8'd5, 8'd4, 8'd10});
    repeat (12) @(negedge clk);
    meas_ch0(hi, per);
    chk("R2 divide 10 high", hi, 5);
    chk("R3 divide 10 period", per, 10);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule